// File: doc/BRIEF.md
# Byte Rotate Execution Unit

This unit executes the rotate instructions of a small accumulator-based processor core. It accepts one instruction at a time on a start strobe, as an opcode byte plus a flag telling whether the opcode came after the extension prefix. It produces the rotated byte and a packed flag byte, and returns the instruction's cycle cost. The unit has four rotate kinds: circular left, circular right, left through carry and right through carry. A short accumulator form exists for each kind, and a prefixed form can name any of seven registers or the byte in memory addressed by the H:L register pair.

The register file stays outside the unit. The core presents all register bytes on a flat read bus, and the unit answers with a one-cycle write-back strobe that names the destination register. That register is always the one that supplied the operand. The memory form runs a read-modify-write on a simple byte port: the unit holds a read request until the read-valid strobe arrives, then issues a one-cycle write of the result to the same address, and finishes on the following cycle. Opcodes outside the rotate set are reported as unhandled and change nothing.

Top module: `rot_unit`

## Requirements
- R1: With `prefixed` low, opcodes 0x07, 0x0F, 0x17 and 0x1F are rotates on the accumulator (operand code 7). The result is written back to code 7 and `cycles` reads 4.
- R2: With `prefixed` high, opcodes with bits [7:5] = 000 are rotates. Bits [4:3] choose the kind (0 circular left, 1 circular right, 2 left through carry, 3 right through carry), and the same field picks the kind in the short forms. Bits [2:0] choose the operand: 0 B, 1 C, 2 D, 3 E, 4 H, 5 L, 6 memory at H:L, 7 A. A register form writes back to that same code, and `cycles` reads 8.
- R3: Circular left puts old bit 7 into both result bit 0 and the carry.
- R4: Circular right puts old bit 0 into both result bit 7 and the carry.
- R5: Left through carry puts `carry_in` into result bit 0 and old bit 7 into the carry.
- R6: Right through carry puts `carry_in` into result bit 7 and old bit 0 into the carry.
- R7: Flag byte layout: zero at bit 7, subtract at bit 6, half-carry at bit 5, carry at bit 4. Subtract, half-carry and bits 3:0 are always 0.
- R8: The zero flag is 1 exactly when the 8-bit result is 0.
- R9: Memory form. One cycle after start, `mem_rd` rises with `mem_addr` = {H,L} and holds until `mem_rvalid`. In the next cycle `mem_wr` pulses for one cycle with the result at the same address. One cycle later `done` and `flag_we` pulse with no register write, and `cycles` reads 16. The carry used is `carry_in` as sampled at start.
- R10: Any other opcode gives `done` and `illegal` one cycle after start, with no register write, no flag write, no memory access, and `cycles` reading 0.
- R11: A register or accumulator form raises `done`, `reg_we` and `flag_we` for exactly one cycle, one cycle after start. A start while `busy` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Instruction strobe, taken when not busy |
| prefixed | input | 1 | Opcode belongs to the extended map |
| opcode | input | 8 | Instruction opcode byte |
| regs_in | input | 8*DW | Register bytes by operand code; slot 6 unused |
| carry_in | input | 1 | Current carry flag |
| mem_rdata | input | DW | Memory read data |
| mem_rvalid | input | 1 | Memory read data valid |
| mem_addr | output | 2*DW | Memory byte address |
| mem_rd | output | 1 | Memory read request |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | DW | Memory write data |
| busy | output | 1 | Memory operation in progress |
| done | output | 1 | Instruction finished |
| illegal | output | 1 | Opcode not handled |
| reg_we | output | 1 | Register write-back strobe |
| reg_sel | output | 3 | Destination operand code |
| reg_wdata | output | DW | Write-back data |
| flag_we | output | 1 | Flag write strobe |
| flags_out | output | 8 | Packed flag byte |
| cycles | output | 5 | Cycle cost of the last instruction |

## Verification
The bench builds the unit with its default 8-bit data width, which gives a 16-bit address. At that width every operand byte can be swept with both carry states through every legal opcode of both maps. The memory forms run with read latencies of zero to two cycles, and a start is injected while the unit is busy. Every opcode outside the rotate set, in both the plain and the prefixed map, is also applied. This brings all-zero results, bit-7/bit-0 wrap-around and the carry-only-zero cases within reach.

// File: rtl/rot_pkg.sv
package rot_pkg;

    typedef enum logic [1:0] {
        ROT_LC = 2'd0,
        ROT_RC = 2'd1,
        ROT_LT = 2'd2,
        ROT_RT = 2'd3
    } rot_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RD   = 2'd1,
        ST_WR   = 2'd2
    } rot_st_e;

    typedef struct packed {
        logic       legal;
        logic       is_mem;
        rot_op_e    op;
        logic [2:0] sel;
        logic [4:0] cycles;
    } rot_dec_t;

    localparam logic [2:0] SEL_MEM = 3'd6;
    localparam logic [2:0] SEL_ACC = 3'd7;

    localparam int FLG_Z = 7;
    localparam int FLG_N = 6;
    localparam int FLG_H = 5;
    localparam int FLG_C = 4;

    localparam logic [4:0] CYC_SHORT = 5'd4;
    localparam logic [4:0] CYC_REG   = 5'd8;
    localparam logic [4:0] CYC_MEM   = 5'd16;

    function automatic logic [7:0] pack_flags(input logic zero, input logic carry);
        logic [7:0] f;
        f = 8'h00;
        f[FLG_Z] = zero;
        f[FLG_C] = carry;
        return f;
    endfunction

endpackage

// File: rtl/rot_decode.sv
module rot_decode
    import rot_pkg::*;
(
    input  logic       prefixed,
    input  logic [7:0] opcode,
    output rot_dec_t   dec
);
    always_comb begin
        dec        = '0;
        dec.op     = rot_op_e'(opcode[4:3]);
        if (!prefixed) begin
            dec.legal  = (opcode[7:5] == 3'b000) && (opcode[2:0] == 3'b111);
            dec.sel    = SEL_ACC;
            dec.cycles = CYC_SHORT;
        end else begin
            dec.legal  = (opcode[7:5] == 3'b000);
            dec.sel    = opcode[2:0];
            dec.is_mem = (opcode[2:0] == SEL_MEM);
            dec.cycles = (opcode[2:0] == SEL_MEM) ? CYC_MEM : CYC_REG;
        end
        if (!dec.legal) begin
            dec.is_mem = 1'b0;
            dec.cycles = 5'd0;
        end
    end
endmodule

// File: rtl/rot_alu.sv
module rot_alu
    import rot_pkg::*;
#(
    parameter int DW = 8
) (
    input  rot_op_e       op,
    input  logic [DW-1:0] val,
    input  logic          cin,
    output logic [DW-1:0] res,
    output logic          cout
);
    always_comb begin
        res  = val;
        cout = 1'b0;
        case (op)
            ROT_LC: begin
                res  = {val[DW-2:0], val[DW-1]};
                cout = val[DW-1];
            end
            ROT_RC: begin
                res  = {val[0], val[DW-1:1]};
                cout = val[0];
            end
            ROT_LT: begin
                res  = {val[DW-2:0], cin};
                cout = val[DW-1];
            end
            ROT_RT: begin
                res  = {cin, val[DW-1:1]};
                cout = val[0];
            end
            default: begin
                res  = val;
                cout = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/rot_unit.sv
module rot_unit
    import rot_pkg::*;
#(
    parameter int DW = 8,
    localparam int AW = 2 * DW
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic            prefixed,
    input  logic [7:0]      opcode,
    input  logic [8*DW-1:0] regs_in,
    input  logic            carry_in,
    input  logic [DW-1:0]   mem_rdata,
    input  logic            mem_rvalid,
    output logic [AW-1:0]   mem_addr,
    output logic            mem_rd,
    output logic            mem_wr,
    output logic [DW-1:0]   mem_wdata,
    output logic            busy,
    output logic            done,
    output logic            illegal,
    output logic            reg_we,
    output logic [2:0]      reg_sel,
    output logic [DW-1:0]   reg_wdata,
    output logic            flag_we,
    output logic [7:0]      flags_out,
    output logic [4:0]      cycles
);
    localparam int IDX_H = 4;
    localparam int IDX_L = 5;

    rot_st_e        st;
    rot_dec_t       dec;
    rot_op_e        op_q;
    logic           cin_q;

    rot_op_e        a_op;
    logic [DW-1:0]  a_val;
    logic           a_cin;
    logic [DW-1:0]  a_res;
    logic           a_cout;
    logic           a_zero;
    logic [AW-1:0]  hl_addr;

    rot_decode u_dec (
        .prefixed (prefixed),
        .opcode   (opcode),
        .dec      (dec)
    );

    // One rotator serves both the register path and the memory path
    always_comb begin
        if (st == ST_RD) begin
            a_op  = op_q;
            a_val = mem_rdata;
            a_cin = cin_q;
        end else begin
            a_op  = dec.op;
            a_val = regs_in[dec.sel*DW +: DW];
            a_cin = carry_in;
        end
    end

    rot_alu #(.DW(DW)) u_alu (
        .op   (a_op),
        .val  (a_val),
        .cin  (a_cin),
        .res  (a_res),
        .cout (a_cout)
    );

    assign a_zero  = (a_res == '0);
    assign hl_addr = {regs_in[IDX_H*DW +: DW], regs_in[IDX_L*DW +: DW]};
    assign busy    = (st != ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            op_q      <= ROT_LC;
            cin_q     <= 1'b0;
            mem_addr  <= '0;
            mem_rd    <= 1'b0;
            mem_wr    <= 1'b0;
            mem_wdata <= '0;
            done      <= 1'b0;
            illegal   <= 1'b0;
            reg_we    <= 1'b0;
            reg_sel   <= 3'd0;
            reg_wdata <= '0;
            flag_we   <= 1'b0;
            flags_out <= 8'h00;
            cycles    <= 5'd0;
        end else begin
            done    <= 1'b0;
            illegal <= 1'b0;
            reg_we  <= 1'b0;
            flag_we <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (start) begin
                        cycles <= dec.cycles;
                        if (!dec.legal) begin
                            done    <= 1'b1;
                            illegal <= 1'b1;
                        end else if (dec.is_mem) begin
                            st       <= ST_RD;
                            op_q     <= dec.op;
                            cin_q    <= carry_in;
                            mem_rd   <= 1'b1;
                            mem_addr <= hl_addr;
                        end else begin
                            done      <= 1'b1;
                            reg_we    <= 1'b1;
                            flag_we   <= 1'b1;
                            reg_sel   <= dec.sel;
                            reg_wdata <= a_res;
                            flags_out <= pack_flags(a_zero, a_cout);
                        end
                    end
                end
                ST_RD: begin
                    if (mem_rvalid) begin
                        mem_rd    <= 1'b0;
                        mem_wr    <= 1'b1;
                        mem_wdata <= a_res;
                        flags_out <= pack_flags(a_zero, a_cout);
                        st        <= ST_WR;
                    end
                end
                ST_WR: begin
                    mem_wr  <= 1'b0;
                    done    <= 1'b1;
                    flag_we <= 1'b1;
                    st      <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    a_r9_rd_wr_excl: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));
    a_r9_addr_held: assert property (@(posedge clk) disable iff (rst)
        (mem_rd && !mem_rvalid) |=> (mem_rd && $stable(mem_addr)));
    a_r9_wr_then_done: assert property (@(posedge clk) disable iff (rst)
        mem_wr |=> (done && flag_we && !reg_we && !mem_wr));
    a_r10_illegal_quiet: assert property (@(posedge clk) disable iff (rst)
        illegal |-> (done && !reg_we && !flag_we && cycles == 5'd0));
    a_r7_flag_layout: assert property (@(posedge clk) disable iff (rst)
        flag_we |-> (flags_out[3:0] == 4'h0 && !flags_out[FLG_N] && !flags_out[FLG_H]));
    a_r8_zero_flag: assert property (@(posedge clk) disable iff (rst)
        reg_we |-> (flags_out[FLG_Z] == (reg_wdata == '0)));
    a_r2_reg_dest: assert property (@(posedge clk) disable iff (rst)
        reg_we |-> (reg_sel != SEL_MEM && (cycles == CYC_SHORT || cycles == CYC_REG)));
    a_r11_busy_ignore: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> (!reg_we && !illegal));
endmodule

// File: tb/rot_unit_bench.sv
module rot_unit_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 8;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            start = 1'b0;
    logic            prefixed = 1'b0;
    logic [7:0]      opcode = 8'h00;
    logic [8*DW-1:0] regs_in = '0;
    logic            carry_in = 1'b0;
    logic [DW-1:0]   mem_rdata = '0;
    logic            mem_rvalid = 1'b0;
    logic [2*DW-1:0] mem_addr;
    logic            mem_rd, mem_wr, busy, done, illegal, reg_we, flag_we;
    logic [DW-1:0]   mem_wdata, reg_wdata;
    logic [2:0]      reg_sel;
    logic [7:0]      flags_out;
    logic [4:0]      cycles;

    int n_checks = 0;
    int n_errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rot_unit #(.DW(DW)) u_rot_unit (
        .clk(clk), .rst(rst), .start(start), .prefixed(prefixed), .opcode(opcode),
        .regs_in(regs_in), .carry_in(carry_in), .mem_rdata(mem_rdata),
        .mem_rvalid(mem_rvalid), .mem_addr(mem_addr), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .mem_wdata(mem_wdata), .busy(busy), .done(done),
        .illegal(illegal), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .flag_we(flag_we), .flags_out(flags_out),
        .cycles(cycles)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    // Arithmetic reference: returns carry*256 + result
    function automatic int model(input int kind, input int v, input int c);
        int r, co;
        case (kind)
            0: begin r = (v * 2) % 256 + v / 128; co = v / 128; end
            1: begin r = v / 2 + (v % 2) * 128;   co = v % 2;   end
            2: begin r = (v * 2) % 256 + c;       co = v / 128; end
            default: begin r = v / 2 + c * 128;   co = v % 2;   end
        endcase
        return co * 256 + r;
    endfunction

    function automatic int flag_byte(input int m);
        return (((m % 256) == 0) ? 128 : 0) + (m / 256) * 16;
    endfunction

    function automatic string kind_req(input int kind);
        case (kind)
            0: return "R3";
            1: return "R4";
            2: return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic fill_regs(input int sel, input int val);
        for (int k = 0; k < 8; k++) regs_in[k*8 +: 8] = 8'(8'hA5 ^ (k * 17));
        regs_in[sel*8 +: 8] = 8'(val);
    endtask

    task automatic run_reg(input bit pfx, input int opc, input int val, input int c,
                           input int sel, input int expc);
        int m, kind;
        string rq;
        kind = (opc / 8) % 4;
        m = model(kind, val, c);
        rq = kind_req(kind);
        fill_regs(sel, val);
        carry_in = c[0];
        prefixed = pfx;
        opcode = 8'(opc);
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        chk(done === 1'b1 && reg_we === 1'b1 && flag_we === 1'b1, "R11", "strobes",
            32'({done, reg_we, flag_we}), 32'h7);
        chk(reg_sel === 3'(sel), pfx ? "R2" : "R1", "reg_sel", 32'(reg_sel), 32'(sel));
        chk(reg_wdata === 8'(m % 256), rq, "result", 32'(reg_wdata), 32'(m % 256));
        chk(flags_out === 8'(flag_byte(m)), "R7 R8", "flags", 32'(flags_out), 32'(flag_byte(m)));
        chk(cycles === 5'(expc), pfx ? "R2" : "R1", "cycles", 32'(cycles), 32'(expc));
        chk(illegal === 1'b0 && mem_rd === 1'b0 && mem_wr === 1'b0, "R11", "side outputs",
            32'({illegal, mem_rd, mem_wr}), 32'h0);
        @(negedge clk);
        chk(done === 1'b0 && reg_we === 1'b0 && flag_we === 1'b0, "R11", "single pulse",
            32'({done, reg_we, flag_we}), 32'h0);
    endtask

    task automatic run_mem(input int opc, input int val, input int c, input int lat,
                           input bit poke);
        int m, kind, addr;
        kind = (opc / 8) % 4;
        m = model(kind, val, c);
        fill_regs(4, val ^ 8'h3C);
        regs_in[5*8 +: 8] = 8'(255 - val);
        addr = (val ^ 8'h3C) * 256 + (255 - val);
        carry_in = c[0];
        prefixed = 1'b1;
        opcode = 8'(opc);
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        carry_in = ~c[0];
        regs_in = ~regs_in;
        chk(mem_rd === 1'b1 && busy === 1'b1 && done === 1'b0, "R9", "read request",
            32'({mem_rd, busy, done}), 32'h6);
        chk(mem_addr === 16'(addr), "R9", "read addr", 32'(mem_addr), 32'(addr));
        for (int i = 0; i < lat; i++) begin
            if (poke && i == 0) begin
                prefixed = 1'b0;
                opcode = 8'h07;
                start = 1'b1;
            end
            @(posedge clk);
            @(negedge clk);
            start = 1'b0;
            chk(mem_rd === 1'b1 && mem_wr === 1'b0 && reg_we === 1'b0 && illegal === 1'b0 &&
                done === 1'b0, poke ? "R11" : "R9", "wait state",
                32'({mem_rd, mem_wr, reg_we, illegal, done}), 32'h10);
            chk(mem_addr === 16'(addr), "R9", "addr held", 32'(mem_addr), 32'(addr));
        end
        mem_rdata = 8'(val);
        mem_rvalid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        mem_rvalid = 1'b0;
        mem_rdata = 8'h00;
        chk(mem_wr === 1'b1 && mem_rd === 1'b0 && done === 1'b0, "R9", "write strobe",
            32'({mem_wr, mem_rd, done}), 32'h4);
        chk(mem_addr === 16'(addr), "R9", "write addr", 32'(mem_addr), 32'(addr));
        chk(mem_wdata === 8'(m % 256), kind_req(kind), "mem result", 32'(mem_wdata), 32'(m % 256));
        @(posedge clk);
        @(negedge clk);
        chk(done === 1'b1 && flag_we === 1'b1 && reg_we === 1'b0 && mem_wr === 1'b0, "R9",
            "finish", 32'({done, flag_we, reg_we, mem_wr}), 32'hC);
        chk(flags_out === 8'(flag_byte(m)), "R7 R8", "mem flags", 32'(flags_out), 32'(flag_byte(m)));
        chk(cycles === 5'd16, "R9", "cycles", 32'(cycles), 32'd16);
    endtask

    task automatic run_bad(input bit pfx, input int opc);
        fill_regs(6, opc);
        prefixed = pfx;
        opcode = 8'(opc);
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        chk(done === 1'b1 && illegal === 1'b1 && reg_we === 1'b0 && flag_we === 1'b0 &&
            mem_rd === 1'b0 && busy === 1'b0, "R10", "unhandled",
            32'({done, illegal, reg_we, flag_we, mem_rd, busy}), 32'h30);
        chk(cycles === 5'd0, "R10", "cycles", 32'(cycles), 32'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        chk(1'b0, "watchdog", "timeout", 32'd0, 32'd1);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk({done, illegal, reg_we, flag_we, mem_rd, mem_wr, busy} === 7'b0, "R11", "reset strobes",
            32'({done, illegal, reg_we, flag_we, mem_rd, mem_wr, busy}), 32'h0);
        chk(flags_out === 8'h00 && cycles === 5'd0, "R7", "reset flags/cycles",
            32'({flags_out, 3'b000, cycles}), 32'h0);

        // R1: short accumulator forms
        for (int k = 0; k < 4; k++)
            for (int v = 0; v < 256; v++)
                for (int c = 0; c < 2; c++)
                    run_reg(1'b0, 8'h07 + k * 8, v, c, 7, 4);

        // R2..R6: prefixed register forms, every operand code but memory
        for (int opc = 0; opc < 32; opc++)
            if (opc % 8 != 6)
                for (int v = 0; v < 256; v++)
                    for (int c = 0; c < 2; c++)
                        run_reg(1'b1, opc, v, c, opc % 8, 8);

        // R9: memory forms with varied read latency
        for (int k = 0; k < 4; k++)
            for (int v = 0; v < 256; v++)
                for (int c = 0; c < 2; c++)
                    run_mem(6 + k * 8, v, c, v % 3, (v % 5 == 0) && (v % 3 != 0));

        // R10: every unhandled code in both maps
        for (int opc = 0; opc < 256; opc++)
            if (!(opc == 8'h07 || opc == 8'h0F || opc == 8'h17 || opc == 8'h1F))
                run_bad(1'b0, opc);
        for (int opc = 32; opc < 256; opc++)
            run_bad(1'b1, opc);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule